// File: doc/BRIEF.md
# Call-Triggered Stack Pointer Snapshot

This block runs alongside a microsequencer and watches every microcode call. Some call targets are the entry point of a new macroinstruction. When a call goes to one of these targets, the block copies the live stack pointer into a saved stack pointer register. The copy is a side effect of the call, so no separate microinstruction is needed to make it. Microcode can later read the saved value back to restore the stack after an abort.

A target counts as an entry point when two conditions hold. First, its upper address bits must place it inside a fixed window of control-store pages. Second, its lowest address bits must match a fixed pattern. With the defaults, the target is 12 bits wide. The window is the set of addresses whose top two bits are `01`, which is pages 4 through 7 of 256 words each. The tail pattern is low two bits equal to `01`.

The block has a small two-state machine, `ST_WATCH` and `ST_TAKEN`:
- When a qualifying call arrives, the machine moves to `ST_TAKEN` (transition "snap").
- With no qualifying call, it returns to `ST_WATCH` (transition "settle").
- It stays in `ST_TAKEN` if a qualifying call arrives again (transition "resnap").
- It stays in `ST_WATCH` if no qualifying call arrives (transition "idle").

While the machine is in `ST_TAKEN`, the snapshot flag is high.

Top module: `sp_snapshot`

## Requirements
- R1: While reset is asserted, the saved stack pointer reads 0 and the snapshot flag is low.
- R2: When the call strobe is high at a clock edge and the target has bits [11:10] = 01 and bits [1:0] = 01, the saved stack pointer holds the stack pointer input after that edge.
- R3: A call whose target has bits [11:10] = 01 but bits [1:0] other than 01 leaves the saved stack pointer unchanged.
- R4: A call whose target has bits [11:10] other than 01 leaves the saved stack pointer unchanged, whatever its low bits are.
- R5: When the call strobe is low, the saved stack pointer is unchanged for any target address or stack pointer value.
- R6: The snapshot flag is high for exactly the cycle after each snapshot edge, and low after every other edge.
- R7: A stack pointer value of all ones (0xFF) is captured unaltered.
- R8: Qualifying calls on consecutive cycles each load their own stack pointer value, and the flag stays high for each of those cycles.
- R9: The value captured is the stack pointer present at the capturing edge, not the value applied in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | High for one cycle per microcode call |
| target_i | input | 12 | Control-store address of the call target |
| sp_i | input | 8 | Current stack pointer |
| saved_sp_o | output | 8 | Saved stack pointer register |
| snap_o | output | 1 | High in the cycle after a snapshot was taken |

## Verification
The first pattern is a call to all 4096 target addresses, with a different stack pointer value each time. This sweep separates the window test from the tail test: each address fails one, both, or neither condition. A second sweep runs with the call strobe low, which shows whether the decode is gated by the strobe. Back-to-back qualifying calls, an all-ones stack pointer, and a stack pointer that changes right after the capturing edge show whether each capture takes the value present at its own edge.

// File: rtl/sp_snapshot_pkg.sv
package sp_snapshot_pkg;
    typedef enum logic {
        ST_WATCH = 1'b0,
        ST_TAKEN = 1'b1
    } snap_state_t;
endpackage

// File: rtl/snap_decode.sv
module snap_decode #(
    parameter int ADDR_W   = 12,
    parameter int WIN_BITS = 2,
    parameter int WIN_VAL  = 1,
    parameter int TAIL_BITS = 2,
    parameter int TAIL_VAL  = 1
) (
    input  logic              call_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic              hit_o
);
    localparam logic [WIN_BITS-1:0] WIN_PAT = WIN_BITS'(WIN_VAL);

    logic in_window;
    logic tail_ok;

    assign in_window = (target_i[ADDR_W-1 -: WIN_BITS] == WIN_PAT);

    generate
        if (TAIL_BITS > 0) begin : g_tail
            localparam logic [TAIL_BITS-1:0] TAIL_PAT = TAIL_BITS'(TAIL_VAL);
            assign tail_ok = (target_i[TAIL_BITS-1:0] == TAIL_PAT);
        end else begin : g_notail
            assign tail_ok = 1'b1;
        end
    endgenerate

    assign hit_o = call_i & in_window & tail_ok;
endmodule

// File: rtl/snap_fsm.sv
module snap_fsm
    import sp_snapshot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic load_o,
    output logic snap_o
);
    snap_state_t state_q;
    snap_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WATCH;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: idle, snap, resnap, settle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: state_d = hit_i ? ST_TAKEN : ST_WATCH;
            ST_TAKEN: state_d = hit_i ? ST_TAKEN : ST_WATCH;
            default:  state_d = ST_WATCH;
        endcase
    end

    // outputs
    always_comb begin
        load_o = hit_i;
        snap_o = 1'b0;
        unique case (state_q)
            ST_WATCH: snap_o = 1'b0;
            ST_TAKEN: snap_o = 1'b1;
            default:  snap_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/snap_store.sv
module snap_store #(
    parameter int SP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [SP_W-1:0] d_i,
    output logic [SP_W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/sp_snapshot.sv
module sp_snapshot #(
    parameter int ADDR_W    = 12,
    parameter int SP_W      = 8,
    parameter int WIN_BITS  = 2,
    parameter int WIN_VAL   = 1,
    parameter int TAIL_BITS = 2,
    parameter int TAIL_VAL  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [SP_W-1:0]   sp_i,
    output logic [SP_W-1:0]   saved_sp_o,
    output logic              snap_o
);
    logic hit;
    logic load;

    snap_decode #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .WIN_VAL(WIN_VAL),
        .TAIL_BITS(TAIL_BITS), .TAIL_VAL(TAIL_VAL)
    ) u_decode (
        .call_i(call_i), .target_i(target_i), .hit_o(hit)
    );

    snap_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .load_o(load), .snap_o(snap_o)
    );

    snap_store #(.SP_W(SP_W)) u_store (
        .clk(clk), .rst_n(rst_n), .load_i(load), .d_i(sp_i), .q_o(saved_sp_o)
    );
endmodule

// File: rtl/sp_snapshot_chk.sv
module sp_snapshot_chk #(
    parameter int ADDR_W = 12,
    parameter int SP_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_i,
    input logic [ADDR_W-1:0] target_i,
    input logic [SP_W-1:0]   sp_i,
    input logic [SP_W-1:0]   saved_sp_o,
    input logic              snap_o
);
    logic qual;
    assign qual = call_i && (target_i[ADDR_W-1 -: 2] == 2'b01) && (target_i[1:0] == 2'b01);

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_state_R1: assert (saved_sp_o == '0 && !snap_o);
        end
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> (saved_sp_o == $past(sp_i)));

    // R3, R4 and R5: non-qualifying edges keep the register
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> $stable(saved_sp_o));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> snap_o);

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> !snap_o);
endmodule

bind sp_snapshot sp_snapshot_chk #(.ADDR_W(ADDR_W), .SP_W(SP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .target_i(target_i),
    .sp_i(sp_i), .saved_sp_o(saved_sp_o), .snap_o(snap_o)
);

// File: tb/sp_snapshot_tb.sv
module sp_snapshot_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       call_i = 1'b0;
    logic [11:0] target_i = '0;
    logic [7:0] sp_i = '0;
    logic [7:0] saved_sp_o;
    logic       snap_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    logic [7:0] m_saved = '0;
    logic [7:0] q_saved[$];
    logic       q_flag[$];
    string      q_tag[$];
    string      phase_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_snapshot u_dut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .target_i(target_i),
        .sp_i(sp_i), .saved_sp_o(saved_sp_o), .snap_o(snap_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected result
    task automatic drive(input logic c, input logic [11:0] t, input logic [7:0] s);
        logic q;
        string tag;
        @(negedge clk);
        call_i = c; target_i = t; sp_i = s;
        q = c && (t[11:10] == 2'b01) && (t[1:0] == 2'b01);
        if (!c)                     tag = "R5";
        else if (q && s == 8'hFF)   tag = "R7";
        else if (q)                 tag = "R2";
        else if (t[11:10] != 2'b01) tag = "R4";
        else                        tag = "R3";
        if (phase_tag != "") tag = phase_tag;
        if (q) m_saved = s;
        q_saved.push_back(m_saved);
        q_flag.push_back(q);
        q_tag.push_back(tag);
    endtask

    // monitor: compare after every active edge
    always @(posedge clk) begin
        #1;
        if (rst_n && q_saved.size() > 0) begin
            logic [7:0] es;
            logic ef;
            string tg;
            es = q_saved.pop_front();
            ef = q_flag.pop_front();
            tg = q_tag.pop_front();
            check(tg, saved_sp_o, es);
            check({tg, "/R6"}, snap_o, ef);
        end
    end

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        call_i = 1'b1; target_i = 12'h401; sp_i = 8'h5A;
        @(negedge clk);
        check("R1", saved_sp_o, 0);
        check("R1", snap_o, 0);
        call_i = 1'b0;
        rst_n = 1'b1;

        // full address sweep with calls (R2, R3, R4, R7)
        for (int a = 0; a < 4096; a++) begin
            drive(1'b1, a[11:0], a[7:0] ^ a[11:4]);
        end
        drive(1'b0, 12'h000, 8'h00);

        // all-ones stack pointer (R7)
        drive(1'b1, 12'h5FD, 8'hFF);
        drive(1'b1, 12'h7FE, 8'h00);

        // no call, qualifying addresses (R5)
        for (int a = 1; a < 4096; a += 4) begin
            if (a[11:10] == 2'b01) drive(1'b0, a[11:0], a[9:2]);
        end

        // back-to-back qualifying calls (R8)
        phase_tag = "R8";
        drive(1'b1, 12'h401, 8'h11);
        drive(1'b1, 12'h405, 8'h22);
        drive(1'b1, 12'h7FD, 8'h33);
        drive(1'b0, 12'h401, 8'h44);

        // stack pointer moves right after the capturing edge (R9)
        phase_tag = "R9";
        drive(1'b1, 12'h6A9, 8'hC3);
        drive(1'b0, 12'h6A9, 8'h3C);
        drive(1'b1, 12'h1A9, 8'h99);
        drive(1'b0, 12'h000, 8'h00);
        phase_tag = "";

        @(negedge clk);
        @(negedge clk);
        done = 1;
        report();
    end
endmodule